// File: doc/BRIEF.md
# Byte-Lane Synchronous Memory with Write Forwarding

This block is a single-port synchronous memory, one word wide across four byte lanes, with a parameter for depth. On every rising clock edge it captures the address, the write word and the write controls. A captured write is committed to the array on the next edge, and any subset of the byte lanes can be written. A global write control forces all lanes. A byte-write qualifier has to be asserted before the individual lane selects take effect. When a cycle enables no lane, it is a read.

Read data passes through an output register. It appears one clock after the read address is captured. A read issued in the cycle right after a write to the same word returns the new bytes. This is done by merging lane by lane: written lanes come from the held write, and the other lanes come from the array. An asynchronous output enable gates the result. High impedance on the outputs is modelled as a valid flag held low, with the data forced to zero.

The data path takes one command per clock and has no back-pressure. There is no ready signal, and a command presented while selected is always accepted. The caller sequences the address, for example a burst counter outside the block.

Top module: `bwsram_core`

## Requirements
- R1: With `cs` high and `gw_n` low, all four lanes of the word at `addr` are written with `wdata`, whatever `bwe_n` and `lane_n` are.
- R2: With `cs` high, `gw_n` high and `bwe_n` low, each lane i with `lane_n[i]` low is written, and only those lanes. Lane i covers data bits [8i+7:8i].
- R3: With `gw_n` high and `bwe_n` high, `lane_n` has no effect and the cycle is a read.
- R4: A selected cycle that enables no lane is a read. Its data and `rvalid` become visible after the second rising edge counted from the edge that captured the address.
- R5: A read captured on the edge right after a write capture to the same address returns the written lanes from that write and the other lanes from the array. This also holds when two writes to that word come back to back.
- R6: `oe_n` high forces `rvalid` low and `rdata` to zero at once, with no clock edge. Dropping it restores the held read data.
- R7: With `cs` low, nothing is written, and the output is not valid after the following edge.
- R8: After reset, `rvalid` is low.
- R9: The output is not valid in the cycle after a write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| cs | input | 1 | Chip select, active high |
| addr | input | AW | Word address |
| wdata | input | 32 | Write word |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Output driven (low models high impedance) |

## Verification
The assertions assume that the write controls are known (not X) on every edge while `rst_n` is high. They also assume that `rst_n` is held for at least one edge before commands start. The latency property assumes that `oe_n` low is the only other input that decides whether data is shown. The bench drives every input at the falling edge from a known idle state. It holds reset for several edges and never leaves a control undriven, so these assumptions hold throughout the sweep.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/bwsram_ctrl.sv
module bwsram_ctrl
  import bwsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  output cmd_e             cmd,
  output logic [LANES-1:0] mask
);
  logic [LANES-1:0] lanes_act;

  // global write overrides; lane selects only count under the qualifier
  always_comb begin
    if (!gw_n)       lanes_act = '1;
    else if (!bwe_n) lanes_act = ~lane_n;
    else             lanes_act = '0;
  end

  always_comb begin
    mask = cs ? lanes_act : '0;
    if (!cs)                 cmd = CMD_IDLE;
    else if (lanes_act != 0) cmd = CMD_WRITE;
    else                     cmd = CMD_READ;
  end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[raddr];
    end
  end
endmodule

// File: rtl/bwsram_rdpath.sv
module bwsram_rdpath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = 8,
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    mem_rd,
  input  logic             lw_vld,
  input  logic [AW-1:0]    lw_addr,
  input  logic [LANES-1:0] lw_mask,
  input  logic [DW-1:0]    lw_data,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  logic          hit;
  logic [DW-1:0] merged;
  logic [DW-1:0] dout;
  logic          dout_vld;

  assign hit = lw_vld && (lw_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && lw_mask[g]) ?
                                        lw_data[g*LANE_W +: LANE_W] :
                                        mem_rd[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_vld <= 1'b0;
      dout     <= '0;
    end else begin
      dout_vld <= rd_go;
      if (rd_go) dout <= merged;
    end
  end

  assign rvalid = dout_vld & ~oe_n;
  assign rdata  = rvalid ? dout : '0;

  // R5: a forwarded lane shows the held write data once loaded
  p_fwd_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && hit && lw_mask[0]) |=>
      dout[LANE_W-1:0] == $past(lw_data[LANE_W-1:0]));
endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
  import bwsram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  cmd_e             in_cmd;
  logic [LANES-1:0] in_mask;

  cmd_e             cmd_q;
  logic [AW-1:0]    a_addr;
  logic [DW-1:0]    a_data;
  logic [LANES-1:0] a_mask;

  logic             lw_vld;
  logic [AW-1:0]    lw_addr;
  logic [DW-1:0]    lw_data;
  logic [LANES-1:0] lw_mask;

  logic [LANES-1:0] arr_we;
  logic [DW-1:0]    mem_rd;

  bwsram_ctrl #(.LANES(LANES)) u_ctrl (
    .cs(cs), .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n),
    .cmd(in_cmd), .mask(in_mask)
  );

  // capture stage: address, data and controls registered together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      a_mask <= '0;
      a_addr <= '0;
      a_data <= '0;
    end else begin
      cmd_q  <= in_cmd;
      a_mask <= in_mask;
      a_addr <= addr;
      a_data <= wdata;
    end
  end

  assign arr_we = (cmd_q == CMD_WRITE) ? a_mask : '0;

  // copy of the write being committed, for forwarding to the next read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_vld  <= 1'b0;
      lw_mask <= '0;
      lw_addr <= '0;
      lw_data <= '0;
    end else begin
      lw_vld  <= (cmd_q == CMD_WRITE);
      lw_mask <= a_mask;
      lw_addr <= a_addr;
      lw_data <= a_data;
    end
  end

  bwsram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .we(arr_we), .waddr(a_addr), .wdata(a_data),
    .raddr(addr), .rdata(mem_rd)
  );

  bwsram_rdpath #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .rd_go(cmd_q == CMD_READ), .rd_addr(a_addr),
    .mem_rd(mem_rd), .lw_vld(lw_vld), .lw_addr(lw_addr), .lw_mask(lw_mask),
    .lw_data(lw_data), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  p_gw_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !gw_n) |=> (arr_we == '1));

  p_lane_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && gw_n && !bwe_n) |=> (arr_we == ~$past(lane_n)));

  p_bwe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |=> (arr_we == '0));

  p_rd_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && gw_n && (bwe_n || (&lane_n))) |=> ##1 (rvalid || oe_n));

  p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (arr_we == '0));

  p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we != '0) |=> !rvalid);
endmodule

// File: tb/bwsram_core_tb.sv
`timescale 1ns/1ps
module bwsram_core_tb;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        gw_n = 1'b1;
  logic        bwe_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic        oe_n = 1'b0;
  logic [31:0] rdata;
  logic        rvalid;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  bwsram_core #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wdata(wdata),
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [31:0] pat(int a, int k);
    return (32'h9E3779B9 * (a + 1)) ^ (32'h01010101 * (k + 3)) ^ (k << 7);
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic c, int a, logic [31:0] d, logic g, logic b, logic [3:0] l);
    @(negedge clk);
    cs = c; addr = AW'(a); wdata = d; gw_n = g; bwe_n = b; lane_n = l;
    @(posedge clk);
  endtask

  task automatic idle();
    step(1'b0, 0, 32'h0, 1'b1, 1'b1, 4'hF);
  endtask

  task automatic rd(int a);
    step(1'b1, a, 32'hDEAD0000, 1'b1, 1'b1, 4'h0);
  endtask

  // read now, check after load edge
  task automatic read_chk(string req, int a, logic [31:0] exp);
    rd(a); idle(); #1;
    chk(req, {31'd0, rvalid}, 32'd1);
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R8 reset rvalid", {31'd0, rvalid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: fill every word with global write, qualifier and lane selects set oddly
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, a, pat(a, 0), 1'b0, a[0], 4'(a));
      ref_mem[a] = pat(a, 0);
    end
    idle(); idle();
    for (int a = 0; a < DEPTH; a++) read_chk("R1 global write", a, ref_mem[a]);

    // R2 + R5: every lane mask, read immediately after the write
    for (int m = 0; m < 16; m++) begin
      step(1'b1, m, pat(m, 5), 1'b1, 1'b0, ~4'(m));
      if (m != 0) ref_mem[m] = lane_merge(ref_mem[m], pat(m, 5), 4'(m));
      rd(m); idle(); #1;
      chk("R5 forward valid", {31'd0, rvalid}, 32'd1);
      chk("R5 forward merge", rdata, ref_mem[m]);
    end
    idle();
    for (int a = 0; a < DEPTH; a++) read_chk("R2 lane store", a, ref_mem[a]);

    // R4: mask 0 with qualifier low is a read; latency one clock after capture
    step(1'b1, 3, 32'h0, 1'b1, 1'b0, 4'hF);
    #1; chk("R4 not yet valid", {31'd0, rvalid}, 32'd0);
    idle(); #1;
    chk("R4 read latency", {31'd0, rvalid}, 32'd1);
    chk("R4 read data", rdata, ref_mem[3]);

    // R3: lane selects ignored without qualifier
    for (int a = 0; a < 4; a++) begin
      step(1'b1, a, 32'h5A5A5A5A, 1'b1, 1'b1, 4'h0);
      idle(); #1;
      chk("R3 treated as read", rdata, ref_mem[a]);
    end

    // R9: no output after a committed write
    step(1'b1, 7, pat(7, 9), 1'b0, 1'b1, 4'hF);
    ref_mem[7] = pat(7, 9);
    idle(); #1;
    chk("R9 write quiet", {31'd0, rvalid}, 32'd0);

    // R7: deselected write has no effect
    step(1'b0, 9, 32'hFFFF0000, 1'b0, 1'b0, 4'h0);
    #1; chk("R7 desel out", {31'd0, rvalid}, 32'd0);
    idle();
    read_chk("R7 desel no write", 9, ref_mem[9]);

    // R5: two back-to-back partial writes, then immediate read
    step(1'b1, 12, pat(12, 21), 1'b1, 1'b0, 4'b1100);
    ref_mem[12] = lane_merge(ref_mem[12], pat(12, 21), 4'b0011);
    step(1'b1, 12, pat(12, 22), 1'b1, 1'b0, 4'b0110);
    ref_mem[12] = lane_merge(ref_mem[12], pat(12, 22), 4'b1001);
    rd(12); idle(); #1;
    chk("R5 double write", rdata, ref_mem[12]);

    // R6: asynchronous output enable
    oe_n = 1'b1; #1;
    chk("R6 oe off valid", {31'd0, rvalid}, 32'd0);
    chk("R6 oe off data", rdata, 32'h0);
    oe_n = 1'b0; #1;
    chk("R6 oe restore", rdata, ref_mem[12]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule